// File: doc/BRIEF.md
# Control Sub-Packet Command Processor

This block takes the payload of a control packet as a stream of 32-bit words and splits it into a chain of word-aligned command records. Each record starts with a header word. The header gives a command code and a count of the argument bytes that follow the two header bytes. Padding after the arguments brings each record to a whole number of words.

The processor executes a small command set against an internal register bank with 10-bit addressing:

- plain register write
- masked register write
- register read
- echo request
- timed pause

Reads and echo requests produce reply records on an output word stream. Each reply carries the requester's 6-bit tag so the host can match it to its request. Records with codes the block does not handle, such as bus-transfer commands, are stepped over using their length field. A record that would extend past the declared payload length is dropped.

The input stream uses a valid/ready handshake and marks the first payload word with a start flag. That flag is accompanied by the payload byte length. The output stream is a valid/ready word stream.

Top module: `ctl_subpkt_engine`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and every register of the bank reads 0.
- R2: A header word holds the command code in bits 31:24 and the argument byte count L in bits 23:16. A record occupies ceil((L+2)/4) words, and the next record starts in the word right after it.
- R3: Code 0x02 with L=6 writes the following word into the register numbered by header bits 9:0.
- R4: Code 0x03 with L=10 takes a value word and then a mask word. It sets reg = (reg & ~mask) | (value & mask).
- R5: Code 0x04 with L=2 replies with two words. The first is {0x05, 0x06, header bits 15:0}, where bits 15:10 hold the tag and bits 9:0 the register number. The second is the register value. Register numbers at or above NUM_REGS read 0, and writes to them are discarded.
- R6: Code 0x00 with L=2 replies with one word, {0x01, 0x02, header bits 15:0}. The tag and the 10-bit ping value are returned unchanged.
- R7: Code 0x10 with L=2 holds `in_ready` low for exactly 1+N cycles after its header is accepted, where N is header bits 15:0 taken as an unsigned count.
- R8: Any other code, and any known code with a different L, has no effect on the registers or the output. It costs one cycle with `in_ready` low.
- R9: A packet is the `in_sof` word plus the following words, ceil(P/4) words in all (one word if P=0), where P is `in_paylen`. A record at byte offset O with O+2+L > P is ignored, and the rest of its packet is discarded. Words arriving outside a packet without `in_sof` are discarded.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` holds still. `in_ready` is never high while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_sof | input | 1 | Marks the first word of a payload |
| in_paylen | input | PAYLEN_W | Payload byte length, sampled with `in_sof` |
| in_data | input | 32 | Input payload word |
| out_valid | output | 1 | Reply word valid |
| out_ready | input | 1 | Downstream takes the reply word |
| out_data | output | 32 | Reply word |

## Verification
A wrong word counter or byte offset shows up quickly. It misaligns the next header, so that packet produces missing, extra or garbled replies, or the block stalls waiting for words that never come. A corrupted register lane stays hidden until a later read returns it, so the stimulus reads back every register it touches, including numbers at the edge of the bank and past it. A faulty pause counter appears immediately as a wrong number of cycles with `in_ready` low before the next header is taken.

// File: rtl/ctlp_pkg.sv
`timescale 1ns/1ps
package ctlp_pkg;

   localparam logic [7:0] OPC_ECHO     = 8'h00;
   localparam logic [7:0] OPC_ECHO_RSP = 8'h01;
   localparam logic [7:0] OPC_WR       = 8'h02;
   localparam logic [7:0] OPC_WRM      = 8'h03;
   localparam logic [7:0] OPC_RD       = 8'h04;
   localparam logic [7:0] OPC_RD_RSP   = 8'h05;
   localparam logic [7:0] OPC_PAUSE    = 8'h10;

   typedef enum logic [2:0] {
      ST_IDLE, ST_HDR, ST_ARG, ST_EXEC, ST_RPL0, ST_RPL1, ST_PAUSE
   } walk_state_t;

   // a command runs only when its code and argument byte count both match
   function automatic logic cmd_legal(input logic [7:0] op, input logic [7:0] len);
      case (op)
         OPC_ECHO, OPC_RD, OPC_PAUSE: cmd_legal = (len == 8'd2);
         OPC_WR:                      cmd_legal = (len == 8'd6);
         OPC_WRM:                     cmd_legal = (len == 8'd10);
         default:                     cmd_legal = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ctl_reg_bank.sv
`timescale 1ns/1ps
module ctl_reg_bank #(
   parameter int          NUM_REGS = 32,
   parameter int          ADDR_W   = 10,
   parameter logic [31:0] RST_VAL  = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [31:0]       wmask,
   output logic [31:0]       rdata
);

   initial begin : prm_chk
      assert (NUM_REGS >= 1 && NUM_REGS <= (1 << ADDR_W))
         else $fatal(1, "NUM_REGS out of range for address width");
   end

   logic [31:0] q [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            q[i] <= RST_VAL;
         else if (we && addr == ADDR_W'(i))
            q[i] <= (q[i] & ~wmask) | (wdata & wmask);
      end

      // R3
      untouched_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && addr == ADDR_W'(i)) |=> $stable(q[i]));
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_REGS; k++)
         if (addr == ADDR_W'(k)) rdata = q[k];
   end

endmodule

// File: rtl/ctl_tick_timer.sv
`timescale 1ns/1ps
module ctl_tick_timer #(
   parameter int TICK_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TICK_W-1:0] load_val,
   output logic              busy,
   output logic              last
);

   logic [TICK_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
   assign last = (cnt_q == TICK_W'(1));

   // R7
   count_reaches_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !load) |=> !busy);

endmodule

// File: rtl/ctl_subpkt_engine.sv
`timescale 1ns/1ps
module ctl_subpkt_engine
   import ctlp_pkg::*;
#(
   parameter int          NUM_REGS = 32,
   parameter int          PAYLEN_W = 9,
   parameter int          TICK_W   = 16,
   parameter logic [31:0] REG_RST  = '0
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic                in_sof,
   input  logic [PAYLEN_W-1:0] in_paylen,
   input  logic [31:0]         in_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [31:0]         out_data
);

   localparam int REG_AW = 10;
   localparam int OFF_W  = PAYLEN_W + 2;
   localparam int WL_W   = PAYLEN_W;

   initial begin : prm_chk
      assert (PAYLEN_W >= 3 && PAYLEN_W <= 16) else $fatal(1, "PAYLEN_W out of range");
      assert (TICK_W >= 16) else $fatal(1, "TICK_W must hold a 16-bit count");
   end

   walk_state_t         st_q;
   logic [OFF_W-1:0]    off_q;
   logic [PAYLEN_W-1:0] plen_q;
   logic [WL_W-1:0]     wleft_q, aleft_q;
   logic [7:0]          op_q;
   logic [15:0]         lo_q;
   logic [31:0]         val_q, msk_q, rd_q;
   logic                go_q, first_q;

   logic [7:0]          h_op, h_len;
   logic [OFF_W-1:0]    base_off, sub_end;
   logic [PAYLEN_W-1:0] plen;
   logic [WL_W-1:0]     wl, nargs;
   logic                fits, hdr_take;
   walk_state_t         nxt_st;

   logic                rb_we;
   logic [31:0]         rb_mask, rb_rdata;
   logic                tm_load, tm_busy, tm_last;

   always_comb begin
      h_op     = in_data[31:24];
      h_len    = in_data[23:16];
      base_off = in_sof ? '0 : off_q;
      plen     = in_sof ? in_paylen : plen_q;
      wl       = in_sof ? WL_W'(((PAYLEN_W+1)'(in_paylen) + (PAYLEN_W+1)'(3)) >> 2) : wleft_q;
      sub_end  = base_off + OFF_W'(h_len) + OFF_W'(2);
      fits     = (sub_end <= OFF_W'(plen));
      nargs    = WL_W'((9'(h_len) + 9'd1) >> 2);
      hdr_take = in_valid && (st_q == ST_HDR || (st_q == ST_IDLE && in_sof));
      nxt_st   = (wleft_q == '0) ? ST_IDLE : ST_HDR;
   end

   assign in_ready  = (st_q == ST_IDLE) || (st_q == ST_HDR) || (st_q == ST_ARG);
   assign out_valid = (st_q == ST_RPL0) || (st_q == ST_RPL1);
   assign out_data  = (st_q == ST_RPL1) ? rd_q :
                      (op_q == OPC_RD)  ? {OPC_RD_RSP, 8'd6, lo_q} :
                                          {OPC_ECHO_RSP, 8'd2, lo_q};

   assign rb_we   = (st_q == ST_EXEC) && go_q && (op_q == OPC_WR || op_q == OPC_WRM);
   assign rb_mask = (op_q == OPC_WRM) ? msk_q : '1;
   assign tm_load = (st_q == ST_EXEC) && go_q && (op_q == OPC_PAUSE) && (lo_q != '0);

   ctl_reg_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(REG_AW), .RST_VAL(REG_RST)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(rb_we), .addr(lo_q[REG_AW-1:0]),
      .wdata(val_q), .wmask(rb_mask), .rdata(rb_rdata));

   ctl_tick_timer #(.TICK_W(TICK_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(TICK_W'(lo_q)),
      .busy(tm_busy), .last(tm_last));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         off_q   <= '0;
         plen_q  <= '0;
         wleft_q <= '0;
         aleft_q <= '0;
         op_q    <= '0;
         lo_q    <= '0;
         val_q   <= '0;
         msk_q   <= '0;
         rd_q    <= '0;
         go_q    <= 1'b0;
         first_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE, ST_HDR: begin
               if (hdr_take) begin
                  if (wl == '0) begin
                     st_q <= ST_IDLE;
                  end else begin
                     wleft_q <= wl - 1'b1;
                     plen_q  <= plen;
                     op_q    <= h_op;
                     lo_q    <= in_data[15:0];
                     first_q <= 1'b1;
                     if (fits) begin
                        go_q    <= cmd_legal(h_op, h_len);
                        off_q   <= base_off + OFF_W'({nargs, 2'b00}) + OFF_W'(4);
                        aleft_q <= nargs;
                        st_q    <= (nargs == '0) ? ST_EXEC : ST_ARG;
                     end else begin
                        go_q    <= 1'b0;
                        aleft_q <= wl - 1'b1;
                        st_q    <= (wl == WL_W'(1)) ? ST_EXEC : ST_ARG;
                     end
                  end
               end
            end
            ST_ARG: begin
               if (in_valid) begin
                  first_q <= 1'b0;
                  if (first_q) val_q <= in_data;
                  else         msk_q <= in_data;
                  aleft_q <= aleft_q - 1'b1;
                  wleft_q <= wleft_q - 1'b1;
                  if (aleft_q == WL_W'(1)) st_q <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               st_q <= nxt_st;
               if (go_q) begin
                  if (op_q == OPC_RD) begin
                     rd_q <= rb_rdata;
                     st_q <= ST_RPL0;
                  end else if (op_q == OPC_ECHO) begin
                     st_q <= ST_RPL0;
                  end else if (op_q == OPC_PAUSE && lo_q != '0) begin
                     st_q <= ST_PAUSE;
                  end
               end
            end
            ST_RPL0: if (out_ready) st_q <= (op_q == OPC_RD) ? ST_RPL1 : nxt_st;
            ST_RPL1: if (out_ready) st_q <= nxt_st;
            ST_PAUSE: if (tm_last) st_q <= nxt_st;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R10
   reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R10
   no_input_during_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R7
   pause_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tm_busy |-> !in_ready);

   // R9
   stray_word_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && in_valid && !in_sof) |=> (st_q == ST_IDLE && !out_valid));

endmodule

// File: tb/sim_ctl_subpkt_engine.sv
`timescale 1ns/1ps
module sim_ctl_subpkt_engine;

   localparam int NREG = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sof = 1'b0;
   logic [8:0]  in_paylen = '0;
   logic [31:0] in_data = '0;
   logic        out_ready;
   logic        in_ready, out_valid;
   logic [31:0] out_data;

   always #2.5 clk = ~clk;

   ctl_subpkt_engine #(.NUM_REGS(NREG)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_sof(in_sof), .in_paylen(in_paylen), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

   int          n_chk = 0, n_bad = 0, cyc = 0;
   bit          bp = 0, fin = 0, hold_pend = 0;
   logic [31:0] hold_d;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] pkt_q[$];
   int          stalls[$];
   int          plen_g;
   bit          sof_en;
   string       cur_tag;
   logic [31:0] mregs [NREG];

   task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, expv);
      end
   endtask

   function automatic logic [31:0] hw(input logic [7:0] op, input logic [7:0] len, input logic [15:0] lo);
      return {op, len, lo};
   endfunction

   // reply monitor and output backpressure, all at the falling edge
   always @(negedge clk) begin
      cyc++;
      if (hold_pend)
         chk(out_valid && out_data == hold_d, "R10 hold", out_data, hold_d);
      out_ready = bp ? (cyc % 3 != 0) : 1'b1;
      if (rst_n && out_valid) begin
         chk(!in_ready, "R10 ready during reply", 32'(in_ready), 32'd0);
         if (out_ready) begin
            if (exp_q.size() == 0) chk(0, "R9 unexpected reply", out_data, 32'h0);
            else chk(out_data == exp_q[0], tag_q[0], out_data, exp_q[0]);
            if (exp_q.size() != 0) begin
               void'(exp_q.pop_front());
               void'(tag_q.pop_front());
            end
         end
      end
      hold_pend = rst_n && out_valid && !out_ready;
      hold_d    = out_data;
   end

   // behavioural reference: walks the packet and predicts replies
   task automatic model_pkt();
      int off = 0;
      while (off < plen_g) begin
         logic [31:0] h, a0, a1;
         int ln, na, rg;
         h  = pkt_q[off/4];
         ln = int'(h[23:16]);
         if (off + 2 + ln > plen_g) break;
         na = (ln + 1) / 4;
         a0 = (na > 0) ? pkt_q[off/4 + 1] : 32'h0;
         a1 = (na > 1) ? pkt_q[off/4 + 2] : 32'h0;
         rg = int'(h[9:0]);
         if (h[31:24] == 8'h02 && ln == 6) begin
            if (rg < NREG) mregs[rg] = a0;
         end else if (h[31:24] == 8'h03 && ln == 10) begin
            if (rg < NREG) mregs[rg] = (mregs[rg] & ~a1) | (a0 & a1);
         end else if (h[31:24] == 8'h04 && ln == 2) begin
            exp_q.push_back({8'h05, 8'd6, h[15:0]}); tag_q.push_back({cur_tag, " read header"});
            exp_q.push_back((rg < NREG) ? mregs[rg] : 32'h0); tag_q.push_back({cur_tag, " read value"});
         end else if (h[31:24] == 8'h00 && ln == 2) begin
            exp_q.push_back({8'h01, 8'd2, h[15:0]}); tag_q.push_back({cur_tag, " echo"});
         end
         off += 4 * (na + 1);
      end
   endtask

   task automatic drive_pkt();
      int n = (plen_g == 0) ? 1 : (plen_g + 3) / 4;
      stalls.delete();
      for (int j = 0; j < n; j++) begin
         int st = 0;
         @(negedge clk);
         in_valid  = 1'b1;
         in_data   = pkt_q[j];
         in_sof    = sof_en && (j == 0);
         in_paylen = 9'(plen_g);
         while (!in_ready) begin st++; @(negedge clk); end
         stalls.push_back(st);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
   endtask

   task automatic run_pkt(input int plen, input string tag);
      plen_g  = plen;
      cur_tag = tag;
      sof_en  = 1'b1;
      model_pkt();
      drive_pkt();
      repeat (60) @(negedge clk);
      chk(exp_q.size() == 0, {tag, " replies outstanding"}, 32'(exp_q.size()), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) mregs[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
      chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);

      // R1: registers start at zero
      pkt_q = '{hw(8'h04, 8'd2, {6'd1, 10'd7})};
      run_pkt(4, "R1");

      // R2 R3: write, read back, echo in one payload
      pkt_q = '{hw(8'h02, 8'd6, 16'h0003), 32'hA5A5_1234,
                hw(8'h04, 8'd2, {6'd9, 10'd3}), hw(8'h00, 8'd2, {6'd5, 10'h155})};
      run_pkt(16, "R2 R3");

      // R4: masked update
      pkt_q = '{hw(8'h03, 8'd10, 16'h0003), 32'hFFFF_0000, 32'h0F0F_0F0F,
                hw(8'h04, 8'd2, {6'd63, 10'd3})};
      run_pkt(16, "R4");

      // R6: echo with extreme fields
      pkt_q = '{hw(8'h00, 8'd2, 16'hFFFF)};
      run_pkt(4, "R6");
      pkt_q = '{hw(8'h00, 8'd2, 16'h0000)};
      run_pkt(4, "R6");

      // R8: unknown code, short write, inbound reply code
      pkt_q = '{hw(8'h20, 8'd5, 16'h0003), 32'h1111_1111, hw(8'h02, 8'd2, 16'h0003),
                hw(8'h05, 8'd2, 16'h0003), hw(8'h04, 8'd2, {6'd2, 10'd3})};
      run_pkt(20, "R8");
      chk(stalls[3] == 1, "R8 skip cost", 32'(stalls[3]), 32'd1);

      // R5: top of bank and beyond
      pkt_q = '{hw(8'h02, 8'd6, 16'd40), 32'hDEAD_BEEF, hw(8'h04, 8'd2, {6'd3, 10'd40}),
                hw(8'h02, 8'd6, 16'd31), 32'h7777_0001, hw(8'h04, 8'd2, {6'd4, 10'd31})};
      run_pkt(24, "R5");

      // R9: record running past the payload end is dropped
      pkt_q = '{hw(8'h02, 8'd6, 16'd5), 32'h1111_0000, hw(8'h02, 8'd6, 16'd6)};
      run_pkt(12, "R9");
      pkt_q = '{hw(8'h04, 8'd2, {6'd10, 10'd5}), hw(8'h04, 8'd2, {6'd11, 10'd6})};
      run_pkt(8, "R9");
      pkt_q = '{hw(8'h00, 8'd2, 16'd1), hw(8'h00, 8'd2, 16'd2)};
      run_pkt(6, "R9");
      // R9: word outside a packet, then an empty payload
      pkt_q = '{hw(8'h00, 8'd2, 16'h0BAD)};
      plen_g = 4; sof_en = 1'b0; drive_pkt();
      pkt_q = '{hw(8'h00, 8'd2, 16'h0BAD)};
      run_pkt(0, "R9");
      chk(out_valid == 1'b0, "R9 no reply", 32'(out_valid), 32'd0);

      // R7: pause lengths
      pkt_q = '{hw(8'h10, 8'd2, 16'd5), hw(8'h00, 8'd2, 16'd21)};
      run_pkt(8, "R7");
      chk(stalls[1] == 6, "R7 pause 5", 32'(stalls[1]), 32'd6);
      pkt_q = '{hw(8'h10, 8'd2, 16'd0), hw(8'h00, 8'd2, 16'd22)};
      run_pkt(8, "R7");
      chk(stalls[1] == 1, "R7 pause 0", 32'(stalls[1]), 32'd1);
      pkt_q = '{hw(8'h10, 8'd2, 16'd300), hw(8'h00, 8'd2, 16'd23)};
      run_pkt(8, "R7");
      chk(stalls[1] == 301, "R7 pause 300", 32'(stalls[1]), 32'd301);

      // R10: replies under backpressure
      bp = 1;
      pkt_q = '{hw(8'h04, 8'd2, {6'd12, 10'd3}), hw(8'h00, 8'd2, 16'h1234),
                hw(8'h04, 8'd2, {6'd13, 10'd31}), hw(8'h04, 8'd2, {6'd14, 10'd5})};
      run_pkt(16, "R10");
      bp = 0;

      fin = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule